// File: doc/BRIEF.md
# Seed-Error Recovery Sequencer

This block is a small bus master that brings a hardware random number generator back into service after its entropy source reports a seed fault. When it is triggered, it reads the generator's status word through a single-transaction valid/ready register bus and then runs one of two recovery procedures. The `MODE` parameter picks the procedure when the block is built.

The conditioning-reset procedure (`MODE = 0`) pulses a reset bit in the control word. It then polls until the hardware finishes the reset, confirms that the latched error has been cleared, and waits for the live error flag to drop. If the status read shows that the generator has already recovered by itself, only the latched error flag is cleared. The pipeline-flush procedure (`MODE = 1`) clears the latched flag, reads and discards a fixed number of data words, and then checks that the flag has not come back.

The block has two triggers. One is an explicit request to check the status. The other reports that a data read returned an all-zero word. While a sequence runs, `busy_o` stays high. The sequence ends with a one-cycle `done_o` pulse, or with a `fatal_o` flag that holds until reset. Register offsets: control at `CR_OFF` (0x00), status at `SR_OFF` (0x04), data at `DR_OFF` (0x08). Status bit 2 is the live seed-error flag, and status bit 6 is the latched seed-error flag (cleared by writing 0). Control bit 30 is the conditioning-reset bit.

Top module: `seed_recovery_seq`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `fatal_o` and `bus_valid_o` are all 0.
- R2: When idle and not fatal, a pulse on `kick_i` or `zero_word_i` makes `busy_o` 1 from the next cycle, and the first transaction is a read of the status word.
- R3: In reset mode, if status bit 2 was 1, the block performs two read-modify-write accesses to the control word. The first writes the value read with bit 30 set. The second writes the value read with bit 30 cleared. All other bits are preserved.
- R4: In reset mode, if status bit 2 was 0, the block makes exactly one status write, equal to the value read with bit 6 cleared. It then finishes with `done_o` and no control access.
- R5: After the reset pulse, the block polls the control word until bit 30 reads 0, then reads the status word. If bit 6 is 1, the result is fatal. Otherwise the block polls until bit 2 reads 0 and then finishes with `done_o`.
- R6: In flush mode, the block writes the status value read with bit 6 cleared, performs exactly `FLUSH_WORDS` (12) data reads, and reads the status word again. If bit 6 is 1 the result is fatal, otherwise `done_o`. No control access is made.
- R7: A poll window of `TIMEOUT_CYCLES` starts when control polling begins. A poll whose condition is still unmet after the window has run out gives `fatal_o`, no earlier than `TIMEOUT_CYCLES` after the reset-clear write and within a few poll periods after that.
- R8: The poll window restarts for every new recovery, so two back-to-back recoveries that each stay inside the window both finish with `done_o`.
- R9: Triggers are ignored while busy and after fatal. `fatal_o` stays 1 until reset, and no bus traffic occurs when not busy.
- R10: At most one transaction is outstanding. The address, direction and write data stay unchanged while `bus_valid_o` waits for `bus_ready_i`.
- R11: `done_o` is a single-cycle pulse. In the cycle where `done_o` or `fatal_o` appears, `busy_o` is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_i | input | 1 | Request a status check and recovery |
| zero_word_i | input | 1 | A data read returned zero; start recovery |
| bus_valid_o | output | 1 | Transaction request valid |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register offset |
| bus_wdata_o | output | 32 | Write data |
| bus_ready_i | input | 1 | Transaction accepted; read data valid |
| bus_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse: recovery finished |
| fatal_o | output | 1 | Recovery failed or timed out; held until reset |

## Verification
A wrong internal state shows up at the bus pins within one transaction. Examples are a missing or extra control write, a bit-30 value that is wrong in the read-modify-write, a flush count other than twelve, or an access to the register the chosen procedure must not touch. The bench register model records each of these. A stale poll timer shows only at the end of a polling wait: `fatal_o` appears at a cycle count outside the expected window, or `fatal_o` appears on a second, otherwise healthy recovery. State that fails to return to idle shows as a missing `done_o` pulse, as `busy_o` still high in the pulse cycle, or as a retrigger that produces new bus traffic.

// File: rtl/seedrec_pkg.sv
package seedrec_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_SR,
    ST_RD_CR_A,
    ST_WR_CR_SET,
    ST_RD_CR_B,
    ST_WR_CR_CLR,
    ST_POLL_CR,
    ST_CHK_STICKY,
    ST_POLL_CUR,
    ST_CLR_STICKY,
    ST_FL_DRAIN,
    ST_FL_CHK,
    ST_FATAL
  } seq_state_e;

  localparam int BIT_CUR    = 2;
  localparam int BIT_STICKY = 6;
  localparam int BIT_CRST   = 30;
endpackage

// File: rtl/seedrec_bus_port.sv
module seedrec_bus_port #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              bus_ready_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              bus_valid_o,
  output logic              bus_write_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  output logic              rsp_o,
  output logic [31:0]       rdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid_o <= 1'b0;
      bus_write_o <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      rsp_o       <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_o <= 1'b0;
      if (bus_valid_o && bus_ready_i) begin
        bus_valid_o <= 1'b0;
        rsp_o       <= 1'b1;
        rdata_o     <= bus_rdata_i;
      end else if (!bus_valid_o && req_i) begin
        bus_valid_o <= 1'b1;
        bus_write_o <= we_i;
        bus_addr_o  <= addr_i;
        bus_wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/seedrec_timer.sv
module seedrec_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || arm_i) cnt <= '0;
    else if (run_i && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired_o = (cnt == LIM);
endmodule

// File: rtl/seedrec_fsm.sv
module seedrec_fsm
  import seedrec_pkg::*;
#(
  parameter int MODE        = 0,
  parameter int ADDR_W      = 8,
  parameter int FLUSH_WORDS = 12,
  parameter logic [ADDR_W-1:0] CR_OFF = 'h00,
  parameter logic [ADDR_W-1:0] SR_OFF = 'h04,
  parameter logic [ADDR_W-1:0] DR_OFF = 'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick_i,
  input  logic              zero_i,
  input  logic              rsp_i,
  input  logic [31:0]       rdata_i,
  input  logic              expired_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       wdata_o,
  output logic              arm_o,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fatal_o
);
  localparam bit FLUSH = (MODE != 0);
  localparam int DCW   = $clog2(FLUSH_WORDS + 1);
  localparam logic [DCW-1:0] DRAIN_LAST = DCW'(FLUSH_WORDS - 1);
  localparam logic [31:0] CRST_M   = 32'h1 << BIT_CRST;
  localparam logic [31:0] STICKY_M = 32'h1 << BIT_STICKY;

  seq_state_e        state;
  logic              pend;
  logic [31:0]       snap;
  logic [DCW-1:0]    drain;
  logic              iss_we;
  logic [ADDR_W-1:0] iss_addr;
  logic [31:0]       iss_wdata;

  // Transaction selected by the current step
  always_comb begin
    iss_we    = 1'b0;
    iss_addr  = SR_OFF;
    iss_wdata = '0;
    case (state)
      ST_RD_CR_A, ST_RD_CR_B, ST_POLL_CR: iss_addr = CR_OFF;
      ST_WR_CR_SET: begin iss_we = 1'b1; iss_addr = CR_OFF; iss_wdata = snap | CRST_M;  end
      ST_WR_CR_CLR: begin iss_we = 1'b1; iss_addr = CR_OFF; iss_wdata = snap & ~CRST_M; end
      ST_CLR_STICKY: begin iss_we = 1'b1; iss_wdata = snap & ~STICKY_M; end
      ST_FL_DRAIN: iss_addr = DR_OFF;
      default: ;
    endcase
  end

  assign run_o = (state == ST_POLL_CR) || (state == ST_CHK_STICKY) || (state == ST_POLL_CUR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pend    <= 1'b0;
      snap    <= '0;
      drain   <= '0;
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      arm_o   <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      fatal_o <= 1'b0;
    end else begin
      req_o  <= 1'b0;
      done_o <= 1'b0;
      arm_o  <= 1'b0;
      if (state == ST_IDLE) begin
        if (kick_i || zero_i) begin
          state  <= ST_RD_SR;
          busy_o <= 1'b1;
        end
      end else if (state == ST_FATAL) begin
        busy_o <= 1'b0;
      end else if (!pend) begin
        req_o   <= 1'b1;
        pend    <= 1'b1;
        we_o    <= iss_we;
        addr_o  <= iss_addr;
        wdata_o <= iss_wdata;
      end else if (rsp_i) begin
        pend <= 1'b0;
        case (state)
          ST_RD_SR: begin
            snap <= rdata_i;
            if (!FLUSH && rdata_i[BIT_CUR]) state <= ST_RD_CR_A;
            else                             state <= ST_CLR_STICKY;
          end
          ST_CLR_STICKY: begin
            if (FLUSH) begin
              drain <= '0;
              state <= ST_FL_DRAIN;
            end else begin
              state <= ST_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
            end
          end
          ST_FL_DRAIN: begin
            drain <= drain + 1'b1;
            if (drain == DRAIN_LAST) state <= ST_FL_CHK;
          end
          ST_FL_CHK: begin
            if (rdata_i[BIT_STICKY]) begin
              state <= ST_FATAL; busy_o <= 1'b0; fatal_o <= 1'b1;
            end else begin
              state <= ST_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
            end
          end
          ST_RD_CR_A: begin snap <= rdata_i; state <= ST_WR_CR_SET; end
          ST_WR_CR_SET: state <= ST_RD_CR_B;
          ST_RD_CR_B: begin snap <= rdata_i; state <= ST_WR_CR_CLR; end
          ST_WR_CR_CLR: begin arm_o <= 1'b1; state <= ST_POLL_CR; end
          ST_POLL_CR: begin
            if (!rdata_i[BIT_CRST]) state <= ST_CHK_STICKY;
            else if (expired_i) begin
              state <= ST_FATAL; busy_o <= 1'b0; fatal_o <= 1'b1;
            end
          end
          ST_CHK_STICKY, ST_POLL_CUR: begin
            if (state == ST_CHK_STICKY && rdata_i[BIT_STICKY]) begin
              state <= ST_FATAL; busy_o <= 1'b0; fatal_o <= 1'b1;
            end else if (!rdata_i[BIT_CUR]) begin
              state <= ST_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
            end else if (expired_i) begin
              state <= ST_FATAL; busy_o <= 1'b0; fatal_o <= 1'b1;
            end else begin
              state <= ST_POLL_CUR;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/seed_recovery_seq.sv
module seed_recovery_seq #(
  parameter int MODE           = 0,
  parameter int ADDR_W         = 8,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int FLUSH_WORDS    = 12,
  parameter logic [ADDR_W-1:0] CR_OFF = 'h00,
  parameter logic [ADDR_W-1:0] SR_OFF = 'h04,
  parameter logic [ADDR_W-1:0] DR_OFF = 'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick_i,
  input  logic              zero_word_i,
  output logic              bus_valid_o,
  output logic              bus_write_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ready_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fatal_o
);
  logic              req, we, rsp, arm, run, expired;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata, rdata;

  seedrec_fsm #(
    .MODE(MODE), .ADDR_W(ADDR_W), .FLUSH_WORDS(FLUSH_WORDS),
    .CR_OFF(CR_OFF), .SR_OFF(SR_OFF), .DR_OFF(DR_OFF)
  ) u_fsm (
    .clk(clk), .rst(rst), .kick_i(kick_i), .zero_i(zero_word_i),
    .rsp_i(rsp), .rdata_i(rdata), .expired_i(expired),
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .arm_o(arm), .run_o(run),
    .busy_o(busy_o), .done_o(done_o), .fatal_o(fatal_o)
  );

  seedrec_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i),
    .bus_valid_o(bus_valid_o), .bus_write_o(bus_write_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .rsp_o(rsp), .rdata_o(rdata)
  );

  seedrec_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .arm_i(arm), .run_i(run), .expired_o(expired)
  );
endmodule

// File: rtl/seed_recovery_seq_chk.sv
module seed_recovery_seq_chk #(
  parameter int MODE   = 0,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CR_OFF = 'h00,
  parameter logic [ADDR_W-1:0] DR_OFF = 'h08
) (
  input logic              clk,
  input logic              rst,
  input logic              kick_i,
  input logic              zero_word_i,
  input logic              bus_valid_o,
  input logic              bus_write_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fatal_o
);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !fatal_o && (kick_i || zero_word_i)) |=> busy_o);

  p_hold_req_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_addr_o)
      && $stable(bus_write_o) && $stable(bus_wdata_o)));

  p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    fatal_o |=> fatal_o);

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !bus_valid_o);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_end_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (done_o || $rose(fatal_o)) |-> !busy_o);

  generate
    if (MODE != 0) begin : g_flush
      p_no_ctrl_r6: assert property (@(posedge clk) disable iff (rst)
        bus_valid_o |-> (bus_addr_o != CR_OFF));
    end else begin : g_reset
      p_no_data_r3: assert property (@(posedge clk) disable iff (rst)
        bus_valid_o |-> (bus_addr_o != DR_OFF));
    end
  endgenerate
endmodule

bind seed_recovery_seq seed_recovery_seq_chk #(
  .MODE(MODE), .ADDR_W(ADDR_W), .CR_OFF(CR_OFF), .DR_OFF(DR_OFF)
) u_chk (
  .clk(clk), .rst(rst), .kick_i(kick_i), .zero_word_i(zero_word_i),
  .bus_valid_o(bus_valid_o), .bus_write_o(bus_write_o),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
  .bus_ready_i(bus_ready_i), .busy_o(busy_o), .done_o(done_o), .fatal_o(fatal_o)
);

// File: tb/seed_recovery_seq_test.sv
module rng_reg_model (
  input  logic        clk,
  input  logic        load,
  input  logic [31:0] sr_init,
  input  int          cr_hold,
  input  int          secs_hold,
  input  logic        stuck,
  input  logic        back,
  input  logic        valid,
  input  logic        write,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic        ready,
  output logic [31:0] rdata,
  output int          n_cr_wr, n_cr_rd, n_sr_wr, n_sr_rd, n_dr_rd, n_viol,
  output logic [31:0] cr_wr0, cr_wr1, sr_wr_val
);
  logic [31:0] cr, sr;
  int hold, secs;
  logic pv, pr, pw;
  logic [7:0] pa;
  logic [31:0] pd;

  always_comb begin
    case (addr)
      8'h00:   rdata = cr;
      8'h04:   rdata = sr;
      default: rdata = 32'h5A5A_0000 | n_dr_rd;
    endcase
  end

  always @(posedge clk) begin
    pv <= valid; pr <= ready; pw <= write; pa <= addr; pd <= wdata;
    if (load) begin
      cr <= 32'h0000_0F04; sr <= sr_init; hold <= 0; secs <= 0; ready <= 1'b0;
      n_cr_wr <= 0; n_cr_rd <= 0; n_sr_wr <= 0; n_sr_rd <= 0; n_dr_rd <= 0; n_viol <= 0;
      cr_wr0 <= '0; cr_wr1 <= '0; sr_wr_val <= 32'hFFFF_FFFF;
      pv <= 1'b0;
    end else begin
      ready <= valid && !ready;
      if (pv && !pr && (!valid || write != pw || addr != pa || wdata != pd)) n_viol <= n_viol + 1;
      if (valid && ready) begin
        if (addr == 8'h00 && write) begin
          n_cr_wr <= n_cr_wr + 1;
          if (n_cr_wr == 0) cr_wr0 <= wdata;
          if (n_cr_wr == 1) cr_wr1 <= wdata;
          if (cr[30] && !wdata[30]) begin
            if (cr_hold == 0) begin
              cr <= wdata;
              if (!stuck) sr[6] <= 1'b0;
              secs <= secs_hold;
              if (secs_hold == 0) sr[2] <= 1'b0;
            end else begin
              cr <= wdata | 32'h4000_0000; hold <= cr_hold;
            end
          end else cr <= wdata;
        end else if (addr == 8'h00) begin
          n_cr_rd <= n_cr_rd + 1;
          if (hold > 0) begin
            hold <= hold - 1;
            if (hold == 1) begin
              cr[30] <= 1'b0;
              if (!stuck) sr[6] <= 1'b0;
              secs <= secs_hold;
              if (secs_hold == 0) sr[2] <= 1'b0;
            end
          end
        end else if (addr == 8'h04 && write) begin
          n_sr_wr <= n_sr_wr + 1; sr_wr_val <= wdata; sr <= sr & wdata;
        end else if (addr == 8'h04) begin
          n_sr_rd <= n_sr_rd + 1;
          if (secs > 0) begin
            secs <= secs - 1;
            if (secs == 1) sr[2] <= 1'b0;
          end
        end else begin
          n_dr_rd <= n_dr_rd + 1;
          if (back) sr[6] <= 1'b1;
        end
      end
    end
  end
endmodule

module seed_recovery_seq_test;
  localparam int TO = 200;
  logic clk = 1'b0, rst = 1'b1, load = 1'b1;
  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, clr_stamp = 0;

  // instance 0: reset procedure; instance 1: flush procedure
  logic        k0 = 0, z0 = 0, k1 = 0, z1 = 0;
  logic        v0, w0, r0, b0, d0, f0, v1, w1, r1, b1, d1, f1;
  logic [7:0]  a0, a1;
  logic [31:0] wd0, rd0, wd1, rd1;
  logic [31:0] sri0 = 0, sri1 = 0;
  int          ch0 = 0, sh0 = 0;
  logic        st0 = 0, bk1 = 0;
  int n0_crw, n0_crr, n0_srw, n0_srr, n0_drr, n0_v;
  int n1_crw, n1_crr, n1_srw, n1_srr, n1_drr, n1_v;
  logic [31:0] c0a, c0b, s0w, c1a, c1b, s1w;

  seed_recovery_seq #(.MODE(0), .TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rst(rst), .kick_i(k0), .zero_word_i(z0),
    .bus_valid_o(v0), .bus_write_o(w0), .bus_addr_o(a0), .bus_wdata_o(wd0),
    .bus_ready_i(r0), .bus_rdata_i(rd0), .busy_o(b0), .done_o(d0), .fatal_o(f0));

  seed_recovery_seq #(.MODE(1), .TIMEOUT_CYCLES(TO)) uut_fl (
    .clk(clk), .rst(rst), .kick_i(k1), .zero_word_i(z1),
    .bus_valid_o(v1), .bus_write_o(w1), .bus_addr_o(a1), .bus_wdata_o(wd1),
    .bus_ready_i(r1), .bus_rdata_i(rd1), .busy_o(b1), .done_o(d1), .fatal_o(f1));

  rng_reg_model m0 (.clk(clk), .load(load), .sr_init(sri0), .cr_hold(ch0), .secs_hold(sh0),
    .stuck(st0), .back(1'b0), .valid(v0), .write(w0), .addr(a0), .wdata(wd0),
    .ready(r0), .rdata(rd0), .n_cr_wr(n0_crw), .n_cr_rd(n0_crr), .n_sr_wr(n0_srw),
    .n_sr_rd(n0_srr), .n_dr_rd(n0_drr), .n_viol(n0_v), .cr_wr0(c0a), .cr_wr1(c0b), .sr_wr_val(s0w));

  rng_reg_model m1 (.clk(clk), .load(load), .sr_init(sri1), .cr_hold(0), .secs_hold(0),
    .stuck(1'b0), .back(bk1), .valid(v1), .write(w1), .addr(a1), .wdata(wd1),
    .ready(r1), .rdata(rd1), .n_cr_wr(n1_crw), .n_cr_rd(n1_crr), .n_sr_wr(n1_srw),
    .n_sr_rd(n1_srr), .n_dr_rd(n1_drr), .n_viol(n1_v), .cr_wr0(c1a), .cr_wr1(c1b), .sr_wr_val(s1w));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (v0 && r0 && w0 && a0 == 8'h00 && !wd0[30]) clr_stamp <= cyc;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; load = 1;
    repeat (3) @(negedge clk);
    rst = 0; load = 0;
    @(negedge clk);
  endtask

  task automatic reload();
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic kick(input bit fl);
    @(negedge clk);
    if (fl) k1 = 1; else k0 = 1;
    @(negedge clk);
    k0 = 0; k1 = 0;
  endtask

  // waits for done or fatal; checks the single-cycle done pulse (R11)
  task automatic wait_end(input bit fl, output bit gd, output bit gf, output int at);
    int n = 0;
    gd = 0; gf = 0; at = 0;
    while (n < 5000 && !gd && !gf) begin
      @(negedge clk); n++;
      gd = fl ? d1 : d0;
      gf = fl ? f1 : f0;
    end
    at = cyc;
    check(gd || gf, "R11 sequence ended", 32'(n), 32'd5000);
    check(!(fl ? b1 : b0), "R11 busy low at end", 32'(fl ? b1 : b0), 0);
    if (gd) begin
      @(negedge clk);
      check(!(fl ? d1 : d0), "R11 done one cycle", 32'(fl ? d1 : d0), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit gd, gf;
    int at, snap;
    do_reset();
    // R1
    check(!b0 && !d0 && !f0 && !v0, "R1 reset state (reset mode)", {b0, d0, f0, v0}, 0);
    check(!b1 && !d1 && !f1 && !v1, "R1 reset state (flush mode)", {b1, d1, f1, v1}, 0);

    // R4: auto-recovered case, latched flag only (bit 8 must be kept)
    sri0 = 32'h140; do_reset();
    kick(0); wait_end(0, gd, gf, at);
    check(gd && !gf, "R4 done", {gd, gf}, 2'b10);
    check(n0_srw == 1 && s0w == 32'h100, "R4 status write value", s0w, 32'h100);
    check(n0_crw == 0 && n0_crr == 0, "R4 no control access", n0_crw + n0_crr, 0);

    // R3/R5: full conditioning reset; retrigger while busy (R9)
    sri0 = 32'h44; ch0 = 3; sh0 = 2; do_reset();
    kick(0);
    repeat (8) @(negedge clk);
    check(b0, "R2 busy during recovery", b0, 1);
    kick(0);
    wait_end(0, gd, gf, at);
    check(gd && !gf, "R5 done after reset", {gd, gf}, 2'b10);
    check(n0_crw == 2, "R3 two control writes", n0_crw, 2);
    check(c0a == 32'h4000_0F04, "R3 set write keeps bits", c0a, 32'h4000_0F04);
    check(c0b == 32'h0000_0F04, "R3 clear write keeps bits", c0b, 32'h0000_0F04);
    check(n0_crr == 2 + ch0 + 1, "R5 control polls", n0_crr, 2 + ch0 + 1);
    check(n0_srr == 1 + sh0 + 1, "R5 status polls", n0_srr, 1 + sh0 + 1);
    check(n0_srw == 0, "R5 no status write", n0_srw, 0);
    repeat (20) @(negedge clk);
    check(n0_crw == 2 && !b0, "R9 retrigger while busy ignored", n0_crw, 2);

    // R5: latched flag still set after reset -> fatal; R9 sticky and no traffic
    sri0 = 32'h44; ch0 = 2; sh0 = 0; st0 = 1; do_reset();
    kick(0); wait_end(0, gd, gf, at);
    check(gf && !gd, "R5 latched flag stuck gives fatal", {gd, gf}, 2'b01);
    snap = n0_crr + n0_srr + n0_crw + n0_srw;
    kick(0); repeat (30) @(negedge clk);
    check(f0 && !b0, "R9 fatal sticky", {f0, b0}, 2'b10);
    check(n0_crr + n0_srr + n0_crw + n0_srw == snap, "R9 no traffic after fatal",
          n0_crr + n0_srr + n0_crw + n0_srw, snap);
    st0 = 0;

    // R7: control reset bit never clears
    sri0 = 32'h44; ch0 = 100000; sh0 = 0; do_reset();
    kick(0); wait_end(0, gd, gf, at);
    check(gf, "R7 timeout on control poll", gf, 1);
    check(at - clr_stamp >= TO && at - clr_stamp <= TO + 15, "R7 timeout window",
          at - clr_stamp, TO);

    // R7: live error never clears
    sri0 = 32'h44; ch0 = 1; sh0 = 100000; do_reset();
    kick(0); wait_end(0, gd, gf, at);
    check(gf && n0_srw == 0, "R7 timeout on status poll", gf, 1);

    // R8: two recoveries, each inside the window, together beyond it
    sri0 = 32'h44; ch0 = 25; sh0 = 0; do_reset();
    kick(0); wait_end(0, gd, gf, at);
    check(gd && !gf, "R8 first recovery", {gd, gf}, 2'b10);
    reload();
    kick(0); wait_end(0, gd, gf, at);
    check(gd && !gf, "R8 second recovery re-armed", {gd, gf}, 2'b10);

    // R2: zero-word trigger, busy next cycle, first access is status read
    sri0 = 32'h40; ch0 = 0; do_reset();
    @(negedge clk); z0 = 1;
    @(negedge clk); z0 = 0;
    check(b0, "R2 busy next cycle after zero word", b0, 1);
    wait_end(0, gd, gf, at);
    check(gd && n0_srr == 1 && n0_srw == 1 && s0w == 0, "R2 zero word recovery", s0w, 0);

    // R6: flush procedure
    sri1 = 32'h40; bk1 = 0; do_reset();
    kick(1); wait_end(1, gd, gf, at);
    check(gd && !gf, "R6 flush done", {gd, gf}, 2'b10);
    check(n1_drr == 12, "R6 twelve data reads", n1_drr, 12);
    check(n1_srw == 1 && s1w == 0, "R6 latched flag cleared", s1w, 0);
    check(n1_srr == 2 && n1_crr + n1_crw == 0, "R6 status reads, no control", n1_srr, 2);

    sri1 = 32'h44; bk1 = 1; do_reset();
    kick(1); wait_end(1, gd, gf, at);
    check(gf && !gd, "R6 flag back after flush gives fatal", {gd, gf}, 2'b01);
    check(n1_drr == 12 && n1_crw == 0, "R6 flush count with live flag", n1_drr, 12);

    // R10
    check(n0_v == 0 && n1_v == 0, "R10 request stable until ready", n0_v + n1_v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule